// File: doc/BRIEF.md
# Cable Reflectometry Test Sequencer

This block sequences a single-pair cable reflectometry measurement under register control. Software programs a handful of configuration words and then sets a start bit. The block then steps through timed phases. First comes a quiet interval before transmission, whose length is chosen from four encoded values. Next comes a transmit window whose length is given in microseconds, and during it the block raises a transmit-enable line for an external modulator. A second encoded quiet interval follows. Finally the block hands the line over to a forced-link state that has no negotiation. A microsecond tick input paces every phase.

At the close of the transmit window the block latches a 12-bit fault word from an external peak detector. The word carries a detected flag, a sign and a 10-bit location. Software decodes it from the result register: sign 1 means open, sign 0 means short, and no detected peak means the cable is good. If a link partner is seen to be active during the first quiet interval, the test is abandoned and both the done and fail flags are set. Tap-range and fault-threshold words are held as plain configuration registers for the measurement engine.

Top module: `cable_test_seq`

## Requirements
- R1: After reset, the registers read as follows. Word 0 (control) reads 0x0000. Word 1 (phase config) reads 0x0000. Word 2 (taps) reads 0x2404: end tap 36 in bits 14:8 and start tap 4 in bits 6:0. Word 3 (transmit length) reads 16000 (0x3E80). Word 4 (threshold) reads 0x043E: offset 4 in bits 14:8 and initial threshold 62 in bits 7:0. Word 5 (result) reads 0x0000. Words 6 and 7 read 0.
- R2: The control word has go in bit 15, done in bit 1 and fail in bit 0. Writing it with bit 15 set while the block is idle or in forced-link mode sets go and clears done, fail and the result word. Go self-clears on the next clock, when the sequence leaves idle. A start written while a test is running is ignored.
- R3: The phases run in a fixed order: pre-silence, transmit, post-silence. Each silence field selects 0, 10, 100 or 1000 times TICKS_PER_MS ticks for codes 0 to 3. Pre-silence is in bits 1:0 of word 1 and post-silence in bits 3:2. The transmit window counts L ticks, where L is word 3. Each phase ends on the first clock after its count is exhausted. With the tick held high, the transmit window therefore lasts L+1 cycles, and post-silence lasts S+1 cycles.
- R4: While the tick input is low, the phase counter holds and the current phase is extended.
- R5: If link activity is high in any pre-silence cycle, the block sets done and fail and returns to idle without ever raising transmit enable. This also applies when pre-silence is expiring in that same cycle.
- R6: Link activity outside pre-silence has no effect.
- R7: At the end of the transmit window the fault word (detected bit 11, sign bit 10, location bits 9:0) is captured into word 5. It is held there until the next accepted start.
- R8: When post-silence ends, forced-link mode goes high and done is set with fail clear. Both stay that way until the next start.
- R9: The level output equals bit 12 of word 1 while transmit enable is high, and is low otherwise.
- R10: Words 1 to 4 can be written and mask their unused bits. Word 1 keeps bits 12 and 3:0. Words 2 and 4 keep bits 14:8 and the low 7 or 8 bits respectively. Word 3 keeps all 16 bits. Writes to word 5, and control writes without bit 15, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr (combinational) |
| usTick | input | 1 | One-microsecond pacing tick |
| linkActive | input | 1 | Link partner activity indication |
| peakWord | input | 12 | Fault word from the peak detector |
| txEnable | output | 1 | Transmit window active |
| txLevelHigh | output | 1 | High drive level selected during transmit |
| forcedLink | output | 1 | Forced-link mode after the test |

## Verification
Two events can collide in one cycle: an abort caused by link activity, and the expiry of the pre-silence count. With pre-silence set to zero, link activity is held high across the single pre-silence cycle. The check is that transmit enable never rises and that the control word reads done and fail. A second collision is a start write that arrives while the block sits in forced-link mode. In the write cycle, go must read set and done cleared, and on the next cycle go must have self-cleared. The sweep covers all sixteen silence-code pairs, and the expected cycle counts for each pair are computed from the encoding.

// File: rtl/cts_pkg.sv
package cts_pkg;

  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;
  localparam int PEAK_W = 12;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PHASE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TAPS   = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXLEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_THRESH = 3'd4;
  localparam logic [ADDR_W-1:0] A_RESULT = 3'd5;

  localparam int GO_BIT    = 15;
  localparam int DONE_BIT  = 1;
  localparam int FAIL_BIT  = 0;
  localparam int LEVEL_BIT = 12;

  localparam logic [REG_W-1:0] TAPS_RST   = 16'h2404;
  localparam logic [REG_W-1:0] TXLEN_RST  = 16'd16000;
  localparam logic [REG_W-1:0] THRESH_RST = 16'h043E;
  localparam logic [REG_W-1:0] PHASE_MASK  = 16'h100F;
  localparam logic [REG_W-1:0] TAPS_MASK   = 16'h7F7F;
  localparam logic [REG_W-1:0] THRESH_MASK = 16'h7FFF;

  typedef struct packed {
    logic acceptGo;
    logic clrGo;
    logic ldPre;
    logic ldTx;
    logic ldPost;
    logic capture;
    logic setDone;
    logic setFail;
  } seqStrobe_t;

  function automatic int silenceMs(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 10;
      2'd2:    return 100;
      default: return 1000;
    endcase
  endfunction

endpackage

// File: rtl/cts_datapath.sv
module cts_datapath
  import cts_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              usTick,
  input  logic [PEAK_W-1:0] peakWord,
  input  seqStrobe_t        strb,
  output logic              goPending,
  output logic              cntZero,
  output logic              levelCfg
);

  localparam int LONG_TICKS = 1000 * TICKS_PER_MS;
  localparam int LONG_W     = $clog2(LONG_TICKS + 1);
  localparam int CNT_W      = (LONG_W > REG_W) ? LONG_W : REG_W;

  logic              goBit, doneBit, failBit;
  logic [REG_W-1:0]  phaseReg, tapsReg, txLenReg, threshReg;
  logic [PEAK_W-1:0] resultReg;
  logic [CNT_W-1:0]  cnt;
  logic              startAcc;

  assign startAcc = regWe && (regAddr == A_CTRL) && regWdata[GO_BIT] && strb.acceptGo;

  // control flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goBit   <= 1'b0;
      doneBit <= 1'b0;
      failBit <= 1'b0;
    end else begin
      if (strb.clrGo)  goBit <= 1'b0;
      else if (startAcc) goBit <= 1'b1;
      if (startAcc) begin
        doneBit <= 1'b0;
        failBit <= 1'b0;
      end else begin
        if (strb.setDone) doneBit <= 1'b1;
        if (strb.setFail) failBit <= 1'b1;
      end
    end
  end

  // configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseReg  <= '0;
      tapsReg   <= TAPS_RST;
      txLenReg  <= TXLEN_RST;
      threshReg <= THRESH_RST;
    end else if (regWe) begin
      case (regAddr)
        A_PHASE:  phaseReg  <= regWdata & PHASE_MASK;
        A_TAPS:   tapsReg   <= regWdata & TAPS_MASK;
        A_TXLEN:  txLenReg  <= regWdata;
        A_THRESH: threshReg <= regWdata & THRESH_MASK;
        default: ;
      endcase
    end
  end

  // fault word capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              resultReg <= '0;
    else if (startAcc)      resultReg <= '0;
    else if (strb.capture)  resultReg <= peakWord;
  end

  // phase counter
  logic [CNT_W-1:0] preTicks, postTicks;
  assign preTicks  = CNT_W'(silenceMs(phaseReg[1:0]) * TICKS_PER_MS);
  assign postTicks = CNT_W'(silenceMs(phaseReg[3:2]) * TICKS_PER_MS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt <= '0;
    else if (strb.ldPre)         cnt <= preTicks;
    else if (strb.ldTx)          cnt <= CNT_W'(txLenReg);
    else if (strb.ldPost)        cnt <= postTicks;
    else if (usTick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign cntZero   = (cnt == '0);
  assign goPending = goBit;
  assign levelCfg  = phaseReg[LEVEL_BIT];

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL: begin
        regRdata[GO_BIT]   = goBit;
        regRdata[DONE_BIT] = doneBit;
        regRdata[FAIL_BIT] = failBit;
      end
      A_PHASE:  regRdata = phaseReg;
      A_TAPS:   regRdata = tapsReg;
      A_TXLEN:  regRdata = txLenReg;
      A_THRESH: regRdata = threshReg;
      A_RESULT: regRdata = REG_W'(resultReg);
      default:  regRdata = '0;
    endcase
  end

  // R2: go self-clears after the sequencer takes it
  p_go_selfclear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrGo |=> !goBit);

  // R4: no tick and no load keeps the counter still
  p_count_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!usTick && !strb.ldPre && !strb.ldTx && !strb.ldPost) |=> $stable(cnt));

  // R7: result only moves on capture or accepted start
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !startAcc) |=> $stable(resultReg));

  // R10: tap word never carries masked bits
  p_taps_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == A_TAPS |=> (tapsReg & ~TAPS_MASK) == '0);

endmodule

// File: rtl/cts_ctrl.sv
module cts_ctrl
  import cts_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       goPending,
  input  logic       cntZero,
  input  logic       linkActive,
  output seqStrobe_t strb,
  output logic       txEnable,
  output logic       forcedLink
);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_TX, S_POST, S_LINK
  } seqState_t;

  seqState_t st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    strb   = '0;
    case (st)
      S_IDLE, S_LINK: begin
        strb.acceptGo = 1'b1;
        if (goPending) begin
          strb.clrGo = 1'b1;
          strb.ldPre = 1'b1;
          stNext     = S_PRE;
        end
      end
      S_PRE: begin
        if (linkActive) begin
          strb.setDone = 1'b1;
          strb.setFail = 1'b1;
          stNext       = S_IDLE;
        end else if (cntZero) begin
          strb.ldTx = 1'b1;
          stNext    = S_TX;
        end
      end
      S_TX: begin
        if (cntZero) begin
          strb.capture = 1'b1;
          strb.ldPost  = 1'b1;
          stNext       = S_POST;
        end
      end
      S_POST: begin
        if (cntZero) begin
          strb.setDone = 1'b1;
          stNext       = S_LINK;
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  assign txEnable   = (st == S_TX);
  assign forcedLink = (st == S_LINK);

  // R5: link activity in pre-silence aborts to idle
  p_abort_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_PRE && linkActive) |=> st == S_IDLE);

  // R3: transmit holds until its count is exhausted
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_TX && !cntZero) |=> st == S_TX);

  // R3: transmit is entered only from pre-silence
  p_tx_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |-> $past(st) == S_PRE);

  // R8: forced-link is entered only from post-silence
  p_link_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(forcedLink) |-> $past(st) == S_POST);

endmodule

// File: rtl/cable_test_seq.sv
module cable_test_seq
  import cts_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              usTick,
  input  logic              linkActive,
  input  logic [PEAK_W-1:0] peakWord,
  output logic              txEnable,
  output logic              txLevelHigh,
  output logic              forcedLink
);

  seqStrobe_t strb;
  logic goPending, cntZero, levelCfg;

  cts_datapath #(.TICKS_PER_MS(TICKS_PER_MS)) dp_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .usTick(usTick),
    .peakWord(peakWord), .strb(strb), .goPending(goPending),
    .cntZero(cntZero), .levelCfg(levelCfg)
  );

  cts_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .goPending(goPending), .cntZero(cntZero),
    .linkActive(linkActive), .strb(strb), .txEnable(txEnable),
    .forcedLink(forcedLink)
  );

  assign txLevelHigh = txEnable & levelCfg;

  // R9: level output never shows outside the transmit window
  p_level_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> !txLevelHigh);

endmodule

// File: tb/cable_test_seq_tb.sv
module cable_test_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TPM = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic        usTick = 1'b1;
  logic        linkActive = 1'b0;
  logic [11:0] peakWord = 12'd0;
  logic        txEnable, txLevelHigh, forcedLink;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cable_test_seq #(.TICKS_PER_MS(TPM)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .usTick(usTick),
    .linkActive(linkActive), .peakWord(peakWord), .txEnable(txEnable),
    .txLevelHigh(txLevelHigh), .forcedLink(forcedLink)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(regRdata);
  endtask

  function automatic int ticksOf(input int code);
    case (code)
      0: return 0;
      1: return 10 * TPM;
      2: return 100 * TPM;
      default: return 1000 * TPM;
    endcase
  endfunction

  task automatic waitLink();
    int n = 0;
    while (!forcedLink && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic runSeq(input int pre, input int post, input int len,
                        input bit lvl, input logic [11:0] pk);
    int lo, hi, po, lvlBad, v;
    wr(3'd1, {3'b0, lvl, 8'b0, 2'(post), 2'(pre)});
    wr(3'd3, 16'(len));
    peakWord = pk;
    wr(3'd0, 16'h8000);
    lo = 0;
    while (!txEnable && lo < 5000) begin lo++; @(negedge clk); end
    chk($sformatf("R3 pre-silence cycles pre=%0d", pre), lo, ticksOf(pre) + 2);
    hi = 0; lvlBad = 0;
    while (txEnable && hi < 70000) begin
      if (txLevelHigh !== lvl) lvlBad++;
      hi++; @(negedge clk);
    end
    chk($sformatf("R3 transmit cycles len=%0d", len), hi, len + 1);
    chk("R9 level during transmit", lvlBad, 0);
    peakWord = ~pk;
    rd(3'd5, v);
    chk("R7 captured fault word", v, int'(pk));
    po = 1;
    @(negedge clk);
    while (!forcedLink && po < 5000) begin po++; @(negedge clk); end
    chk($sformatf("R3 post-silence cycles post=%0d", post), po, ticksOf(post) + 1);
    rd(3'd0, v);
    chk("R8 done without fail", v, 16'h0002);
    rd(3'd5, v);
    chk("R7 fault word held", v, int'(pk));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, n, seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd0, v); chk("R1 control", v, 16'h0000);
    rd(3'd1, v); chk("R1 phase", v, 16'h0000);
    rd(3'd2, v); chk("R1 taps", v, 16'h2404);
    rd(3'd3, v); chk("R1 txlen", v, 16000);
    rd(3'd4, v); chk("R1 threshold", v, 16'h043E);
    rd(3'd5, v); chk("R1 result", v, 0);
    rd(3'd6, v); chk("R1 spare6", v, 0);
    rd(3'd7, v); chk("R1 spare7", v, 0);
    chk("R1 outputs idle", {txEnable, txLevelHigh, forcedLink}, 0);

    // R10 masks and ignored writes
    wr(3'd1, 16'hFFFF); rd(3'd1, v); chk("R10 phase mask", v, 16'h100F);
    wr(3'd2, 16'hFFFF); rd(3'd2, v); chk("R10 taps mask", v, 16'h7F7F);
    wr(3'd3, 16'hFFFF); rd(3'd3, v); chk("R10 txlen", v, 16'hFFFF);
    wr(3'd4, 16'hFFFF); rd(3'd4, v); chk("R10 threshold mask", v, 16'h7FFF);
    wr(3'd5, 16'hFFFF); rd(3'd5, v); chk("R10 result read-only", v, 0);
    wr(3'd0, 16'h7FFF); rd(3'd0, v); chk("R10 control without go", v, 0);
    chk("R10 no start without go", {txEnable, forcedLink}, 0);

    // R3 R7 R8 R9 sweep over all silence-code pairs
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        runSeq(p, q, (p * 4 + q) % 5, 1'((p + q) & 1), 12'(p * 211 + q * 97 + 2048));
      end
    end

    // R2 start in forced-link mode clears flags and result; go self-clears
    @(negedge clk);
    wr(3'd0, 16'h8000);
    rd(3'd0, v); chk("R2 go set, done cleared", v, 16'h8000);
    rd(3'd5, v); chk("R2 result cleared", v, 0);
    @(negedge clk);
    rd(3'd0, v); chk("R2 go self-cleared", v, 0);
    chk("R8 forced-link left on start", forcedLink, 0);
    waitLink();

    // R2 start while running is ignored
    wr(3'd1, 16'h0001);
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h8000);
    repeat (3) @(negedge clk);
    wr(3'd0, 16'h8000);
    rd(3'd0, v); chk("R2 busy start ignored", v, 0);
    waitLink();
    rd(3'd0, v); chk("R2 busy run completes", v, 16'h0002);

    // R4 tick stall extends transmit
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'd5);
    wr(3'd0, 16'h8000);
    n = 0;
    while (!txEnable && n < 100) begin n++; @(negedge clk); end
    n = 0;
    while (txEnable && n < 100) begin
      n++;
      if (n == 2) usTick = 1'b0;
      if (n == 9) usTick = 1'b1;
      @(negedge clk);
    end
    chk("R4 stalled transmit cycles", n, 13);
    waitLink();

    // R5 abort in the middle of pre-silence
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h8000);
    repeat (20) @(negedge clk);
    linkActive = 1'b1;
    @(negedge clk);
    linkActive = 1'b0;
    seen = 0;
    for (int i = 0; i < 150; i++) begin
      if (txEnable || forcedLink) seen++;
      @(negedge clk);
    end
    chk("R5 no transmit after abort", seen, 0);
    rd(3'd0, v); chk("R5 done and fail", v, 16'h0003);

    // R5 abort coinciding with pre-silence expiry
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h8000);
    linkActive = 1'b1;
    @(negedge clk);
    @(negedge clk);
    linkActive = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (txEnable) seen++;
      @(negedge clk);
    end
    chk("R5 abort wins over expiry", seen, 0);
    rd(3'd0, v); chk("R5 flags on same-cycle abort", v, 16'h0003);

    // R6 link activity outside pre-silence
    wr(3'd1, 16'h0004);
    wr(3'd3, 16'd4);
    linkActive = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 ignored in idle", {txEnable, forcedLink}, 0);
    linkActive = 1'b0;
    wr(3'd0, 16'h8000);
    n = 0;
    while (!txEnable && n < 100) begin n++; @(negedge clk); end
    linkActive = 1'b1;
    waitLink();
    repeat (4) @(negedge clk);
    chk("R6 forced-link kept", forcedLink, 1);
    rd(3'd0, v); chk("R6 completed without fail", v, 16'h0002);
    linkActive = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule